// File: doc/BRIEF.md
# Rotated Byte Immediate Expander

This block widens a compact 12-bit immediate field from a data-processing instruction into a full 32-bit operand. The low eight bits are a byte seed. The upper four bits are a rotate count, and the block doubles that count before using it. The seed, padded with zeros to 32 bits, is rotated right by that even amount, and any bit that leaves the bottom re-enters at the top. A single mode input can complement the result, which serves move-negative style instructions. The block also returns the carry-out of the rotation, which the execute stage uses to update its flags.

The rotator is a log-structured barrel of four conditional stages that rotate by 2, 4, 8 and 16 bit positions. Each stage is driven by one bit of the rotate count. An optional output register holds the operand and the carry for one cycle, so the block can sit at a pipeline boundary. The register is enabled by default. When it is disabled, the block is purely combinational.

Top module: `rimm_expander`

## Requirements
- R1: The field is decoded as follows: bits [7:0] are an unsigned seed from 0 to 255, and bits [11:8] are a count n. The applied right rotation is 2*n, so only even amounts from 0 to 30 occur. For example, field 0x13C gives 0x0000000F.
- R2: The seed, zero-extended to 32 bits, is rotated right with wrap-around from bit 0 into bit 31. Field 0x4FF gives 0xFF000000.
- R3: When the count is zero, the operand equals the seed zero-extended to 32 bits.
- R4: Field 0xF01 gives 0x00000004, field 0xD01 gives 0x00000040, and field 0xFFF gives 0x000003FC.
- R5: When `invert` is 1, the operand is the bitwise complement of the rotated value. Field 0x000 gives 0xFFFFFFFF, field 0x0EE gives 0xFFFFFF11, and field 0x4FF gives 0x00FFFFFF.
- R6: When the count is zero, `carry_out` equals `carry_in`.
- R7: When the count is non-zero, `carry_out` equals bit 31 of the rotated value before any complement, in either mode.
- R8: With the output register enabled, the outputs follow their inputs one clock later. While `rst_n` is low, the operand and `carry_out` are 0.
- R9: In non-inverted mode, the operand contains exactly as many 1 bits as the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| imm_field | input | 12 | Immediate field: count in [11:8], seed in [7:0] |
| invert | input | 1 | 1 selects the complemented (move-negative) result |
| carry_in | input | 1 | Current carry flag, passed through when the count is zero |
| operand | output | 32 | Expanded 32-bit operand |
| carry_out | output | 1 | Carry-out of the rotation |

## Verification
The assertions check the following on every cycle: the barrel keeps the number of 1 bits, a zero count passes the seed through, the carry follows `carry_in` on a zero count, and otherwise the carry matches the top bit of the pre-complement value. In inverted mode, the complemented operand is checked to hold exactly 32 minus the seed's count of 1 bits. Only the bench's scenarios can show that each count picks the right rotation amount and direction. The bench does this by sweeping every field value in both modes against its own reference rotate, alongside the listed constants, the one-cycle latency and the reset value.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
    parameter int SEED_W  = 8;
    parameter int CNT_W   = 4;
    parameter int WORD_W  = 32;
    parameter int FIELD_W = SEED_W + CNT_W;
endpackage

// File: rtl/rimm_rot_stage.sv
module rimm_rot_stage #(
    parameter int W     = 32,
    parameter int SHIFT = 2
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // fixed right rotation by SHIFT, bypassed when en is low
    assign dout = en ? {din[SHIFT-1:0], din[W-1:SHIFT]} : din;
endmodule

// File: rtl/rimm_barrel.sv
module rimm_barrel
    import rimm_pkg::*;
(
    input  logic [SEED_W-1:0] seed,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] rotated
);
    localparam int PAD_W = WORD_W - SEED_W;

    logic [WORD_W-1:0] tap [CNT_W+1];

    assign tap[0] = {{PAD_W{1'b0}}, seed};

    // count bit i enables a rotation by 2^(i+1)
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        rimm_rot_stage #(
            .W     (WORD_W),
            .SHIFT (2 << i)
        ) u_stage (
            .en   (count[i]),
            .din  (tap[i]),
            .dout (tap[i+1])
        );
    end

    assign rotated = tap[CNT_W];

    always_comb begin
        AST_SEED_PASS: assert (count != '0 || rotated == {{PAD_W{1'b0}}, seed}); // R3
        AST_ONES_KEPT: assert ($countones(rotated) == $countones(seed)); // R9
    end
endmodule

// File: rtl/rimm_expander.sv
module rimm_expander
    import rimm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] imm_field,
    input  logic               invert,
    input  logic               carry_in,
    output logic [WORD_W-1:0]  operand,
    output logic               carry_out
);
    logic [SEED_W-1:0] seed;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] rotated;
    logic [WORD_W-1:0] op_next;
    logic              c_next;

    assign seed  = imm_field[SEED_W-1:0];
    assign count = imm_field[FIELD_W-1:SEED_W];

    rimm_barrel u_barrel (
        .seed    (seed),
        .count   (count),
        .rotated (rotated)
    );

    assign op_next = invert ? ~rotated : rotated;
    assign c_next  = (count == '0) ? carry_in : rotated[WORD_W-1];

    if (REG_OUT) begin : g_reg
        logic primed;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                operand   <= '0;
                carry_out <= 1'b0;
                primed    <= 1'b0;
            end else begin
                operand   <= op_next;
                carry_out <= c_next;
                primed    <= 1'b1;
            end
        end

        AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(count) == '0) |-> carry_out == $past(carry_in)); // R6
        AST_CARRY_MSB: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(count) != '0) |->
            carry_out == ($past(invert) ? ~operand[WORD_W-1] : operand[WORD_W-1])); // R7
        AST_INV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(invert)) |->
            $countones(operand) == WORD_W - $countones($past(seed))); // R5
    end else begin : g_comb
        assign operand   = op_next;
        assign carry_out = c_next;
    end
endmodule

// File: tb/rimm_expander_tb.sv
module rimm_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] imm_field = '0;
    logic        invert = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] operand;
    logic        carry_out;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [31:0] op;
        logic        c;
        int          pop;
        logic        inv;
        string       tag_op;
        string       tag_c;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    rimm_expander u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imm_field (imm_field),
        .invert    (invert),
        .carry_in  (carry_in),
        .operand   (operand),
        .carry_out (carry_out)
    );

    function automatic logic [31:0] ref_rot(input logic [7:0] s, input logic [3:0] n);
        logic [63:0] dbl;
        dbl = {24'b0, s, 24'b0, s} >> (2 * n);
        return dbl[31:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] f, input logic inv, input logic cin, input string tag);
        exp_t e;
        logic [31:0] r;
        @(negedge clk);
        imm_field = f;
        invert    = inv;
        carry_in  = cin;
        r = ref_rot(f[7:0], f[11:8]);
        e.op     = inv ? ~r : r;
        e.c      = (f[11:8] == 4'd0) ? cin : r[31];
        e.pop    = $countones(f[7:0]);
        e.inv    = inv;
        e.tag_op = tag;
        e.tag_c  = (f[11:8] == 4'd0) ? "R6" : "R7";
        q.push_back(e);
    endtask

    // monitor: one result per cycle, sampled 2 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(operand == e.op, e.tag_op, operand, e.op);
                chk(carry_out == e.c, e.tag_c, {31'b0, carry_out}, {31'b0, e.c});
                if (!e.inv)
                    chk($countones(operand) == e.pop, "R9", $countones(operand), e.pop);
            end
        end
    end

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(operand == 32'd0, "R8 reset operand", operand, 32'd0);
        chk(carry_out == 1'b0, "R8 reset carry", {31'b0, carry_out}, 32'd0);
        rst_n = 1'b1;

        drive(12'h13C, 1'b0, 1'b0, "R1 decode");
        drive(12'h4FF, 1'b0, 1'b0, "R2 wrap");
        drive(12'h0A5, 1'b0, 1'b1, "R3 no rotate");
        drive(12'hF01, 1'b0, 1'b0, "R4 0xF01");
        drive(12'hD01, 1'b0, 1'b1, "R4 0xD01");
        drive(12'hFFF, 1'b0, 1'b0, "R4 0xFFF");
        drive(12'h000, 1'b1, 1'b0, "R5 inv zero");
        drive(12'h0EE, 1'b1, 1'b1, "R5 inv 0xEE");
        drive(12'h4FF, 1'b1, 1'b0, "R5 inv 0x4FF");
        drive(12'h180, 1'b1, 1'b0, "R7 inv carry");

        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 4096; f++) begin
                logic [11:0] fv;
                fv = f[11:0];
                drive(fv, m[0], fv[0] ^ fv[5] ^ m[0],
                      m[0] ? "R5 sweep" : (fv[11:8] == 4'd0 ? "R3 sweep" : "R2 sweep"));
            end
        end

        repeat (3) @(posedge clk);

        // R8 latency: output must not move before the next edge
        @(negedge clk);
        begin
            logic [31:0] held;
            held = operand;
            imm_field = 12'h4FF;
            invert    = 1'b0;
            carry_in  = 1'b0;
            #1;
            chk(operand == held, "R8 hold before edge", operand, held);
            @(posedge clk);
            #2;
            chk(operand == 32'hFF00_0000, "R8 after one edge", operand, 32'hFF00_0000);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule